// File: doc/BRIEF.md
# Gap-Free Reciprocal Frequency Counter

This block measures the frequency of a digital input against a local reference clock. It uses the reciprocal method. It counts whole reference-clock cycles across an integer number of input periods. Each gate spans at least a nominal interval and always ends on an input rising edge. The host divides the two counts it receives to get the frequency and does any averaging or statistics on the stream of results.

Gates run back to back. The rising edge that closes one gate also opens the next, so no input period is lost between measurements. Every result carries the event count and the reference-cycle count of its gate, plus a flag marking a timeout. The result is presented for one cycle on a valid strobe, for capture into an on-chip buffer. With the default gate of 1,562,500 cycles at 200 MHz, the block produces 128 results per second.

If the input stops, a gate cannot close. After a fixed multiple of the nominal interval the block then emits a timeout result. It goes idle until the next rising edge opens a fresh gate.

Top module: `recip_freq_counter`

## Requirements
- R1: The input is sampled through SYNC_STAGES (default 2) flops. Only a low-to-high transition counts as an event. A level sampled at clock k reaches the counters at clock k+SYNC_STAGES, and the edge detector compares it with the level one clock older.
- R2: After reset, res_valid, res_timeout, res_events and res_ref_cycles are all 0. The block starts idle. The first rising edge opens a gate and produces no result.
- R3: An open gate closes on the first rising edge whose distance from the opening edge is at least GATE_CYCLES reference clocks. res_ref_cycles is that distance in clocks.
- R4: res_events is the number of rising edges after the opening edge, up to and including the closing edge. This is the number of whole input periods in the gate.
- R5: The closing edge of one gate is the opening edge of the next. The clocks between two consecutive non-timeout res_valid pulses equal the res_ref_cycles of the later result.
- R6: If a gate is still open when its distance reaches TMO_MULT*GATE_CYCLES clocks and no edge is seen in that clock, a result is emitted with res_timeout=1, res_events=0 and res_ref_cycles=TMO_MULT*GATE_CYCLES. The block then returns to idle.
- R7: The event count saturates at all ones (2^EVT_W-1) instead of wrapping. A non-timeout result always has a non-zero event count.
- R8: res_valid is high for exactly one clock. It rises one clock after the counters see the closing edge, or the timeout. The result fields hold their value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all counting is in this domain |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous signal under measurement |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_timeout | output | 1 | Result ended by timeout rather than an input edge |
| res_events | output | EVT_W (16) | Whole input periods in the gate |
| res_ref_cycles | output | REF_W (32) | Reference clocks spanned by the gate |

## Verification
The input is driven as square waves of three periods against a shortened gate. The first period divides the gate exactly, so closure lands exactly on the nominal interval. The second does not divide it, so the gate must overrun to the next edge. The third is fast enough to push the event count into saturation. A stretch with the input held low tells a timeout apart from a normal close. The edges after it show that an idle block reopens without emitting a result. The spacing between successive valid strobes is compared with the reported cycle count to show that consecutive gates share their boundary edge.

// File: rtl/rfc_pkg.sv
`timescale 1ns/1ps
package rfc_pkg;
   typedef enum logic {
      GATE_IDLE = 1'b0,
      GATE_OPEN = 1'b1
   } gate_state_e;
endpackage

// File: rtl/rfc_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser followed by a rising-edge detector.
module rfc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/rfc_gate_ctrl.sv
`timescale 1ns/1ps
// Gate timing plus event and reference counters; reports a closing gate combinationally.
module rfc_gate_ctrl
   import rfc_pkg::*;
#(
   parameter int unsigned GATE_CYCLES = 1562500,
   parameter int unsigned TMO_MULT    = 4,
   parameter int unsigned EVT_W       = 16,
   parameter int unsigned REF_W       = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic             done,
   output logic             done_tmo,
   output logic [EVT_W-1:0] done_evt,
   output logic [REF_W-1:0] done_ref
);
   localparam logic [63:0]      TMO_CYCLES = 64'(GATE_CYCLES) * 64'(TMO_MULT);
   localparam logic [REF_W-1:0] GATE_REF   = REF_W'(GATE_CYCLES);
   localparam logic [REF_W-1:0] TMO_REF    = REF_W'(TMO_CYCLES);
   localparam logic [EVT_W-1:0] EVT_MAX    = {EVT_W{1'b1}};
   localparam logic [REF_W-1:0] REF_ONE    = REF_W'(1);

   gate_state_e      state_q;
   logic [REF_W-1:0] ref_q;
   logic [EVT_W-1:0] evt_q;
   logic [EVT_W-1:0] evt_inc;
   logic             close_now;
   logic             tmo_now;

   always_comb begin
      evt_inc   = (evt_q == EVT_MAX) ? EVT_MAX : evt_q + EVT_W'(1);
      close_now = (state_q == GATE_OPEN) && rise && (ref_q >= GATE_REF);
      tmo_now   = (state_q == GATE_OPEN) && !rise && (ref_q == TMO_REF);
      done      = close_now || tmo_now;
      done_tmo  = tmo_now;
      done_evt  = tmo_now ? '0 : evt_inc;
      done_ref  = ref_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= GATE_IDLE;
         ref_q   <= '0;
         evt_q   <= '0;
      end else if (state_q == GATE_IDLE) begin
         if (rise) begin
            state_q <= GATE_OPEN;
            ref_q   <= REF_ONE;
            evt_q   <= '0;
         end
      end else if (close_now) begin
         ref_q <= REF_ONE;
         evt_q <= '0;
      end else if (tmo_now) begin
         state_q <= GATE_IDLE;
         ref_q   <= '0;
         evt_q   <= '0;
      end else begin
         ref_q <= ref_q + REF_ONE;
         if (rise) evt_q <= evt_inc;
      end
   end
endmodule

// File: rtl/rfc_result_reg.sv
`timescale 1ns/1ps
// Result holding register with one-cycle valid strobe.
module rfc_result_reg #(
   parameter int unsigned EVT_W = 16,
   parameter int unsigned REF_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_tmo,
   input  logic [EVT_W-1:0] load_evt,
   input  logic [REF_W-1:0] load_ref,
   output logic             valid,
   output logic             tmo,
   output logic [EVT_W-1:0] evt,
   output logic [REF_W-1:0] refc
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         tmo   <= 1'b0;
         evt   <= '0;
         refc  <= '0;
      end else begin
         valid <= load;
         if (load) begin
            tmo  <= load_tmo;
            evt  <= load_evt;
            refc <= load_ref;
         end
      end
   end
endmodule

// File: rtl/recip_freq_counter.sv
`timescale 1ns/1ps
module recip_freq_counter #(
   parameter int unsigned GATE_CYCLES = 1562500,
   parameter int unsigned TMO_MULT    = 4,
   parameter int unsigned EVT_W       = 16,
   parameter int unsigned REF_W       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             sig_in,
   output logic             res_valid,
   output logic             res_timeout,
   output logic [EVT_W-1:0] res_events,
   output logic [REF_W-1:0] res_ref_cycles
);
   localparam logic [63:0] TMO_SPAN = 64'(GATE_CYCLES) * 64'(TMO_MULT);

   initial begin : param_check
      if (GATE_CYCLES < 2)   $error("gate must span at least two clocks");
      if (TMO_MULT < 2)      $error("timeout multiple must be at least two");
      if (SYNC_STAGES < 2)   $error("synchroniser needs at least two stages");
      if (EVT_W < 2 || EVT_W > 32) $error("event width out of range");
      if (REF_W < 8 || REF_W > 48) $error("reference width out of range");
      if ((TMO_SPAN >> REF_W) != 64'd0) $error("reference counter too narrow for timeout span");
   end

   logic             rise;
   logic             done;
   logic             done_tmo;
   logic [EVT_W-1:0] done_evt;
   logic [REF_W-1:0] done_ref;

   rfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk_ref),
      .rst_n(rst_n),
      .din  (sig_in),
      .rise (rise)
   );

   rfc_gate_ctrl #(
      .GATE_CYCLES(GATE_CYCLES),
      .TMO_MULT   (TMO_MULT),
      .EVT_W      (EVT_W),
      .REF_W      (REF_W)
   ) u_gate (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .rise    (rise),
      .done    (done),
      .done_tmo(done_tmo),
      .done_evt(done_evt),
      .done_ref(done_ref)
   );

   rfc_result_reg #(.EVT_W(EVT_W), .REF_W(REF_W)) u_res (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .load    (done),
      .load_tmo(done_tmo),
      .load_evt(done_evt),
      .load_ref(done_ref),
      .valid   (res_valid),
      .tmo     (res_timeout),
      .evt     (res_events),
      .refc    (res_ref_cycles)
   );
endmodule

// File: rtl/rfc_checker.sv
`timescale 1ns/1ps
module rfc_checker #(
   parameter int unsigned GATE_CYCLES = 1562500,
   parameter int unsigned TMO_MULT    = 4,
   parameter int unsigned EVT_W       = 16,
   parameter int unsigned REF_W       = 32
) (
   input logic             clk_ref,
   input logic             rst_n,
   input logic             res_valid,
   input logic             res_timeout,
   input logic [EVT_W-1:0] res_events,
   input logic [REF_W-1:0] res_ref_cycles
);
   localparam logic [REF_W-1:0] GATE_REF = REF_W'(GATE_CYCLES);
   localparam logic [REF_W-1:0] TMO_REF  = REF_W'(64'(GATE_CYCLES) * 64'(TMO_MULT));

   // R8
   valid_single_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R8
   data_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !res_valid |-> ($stable(res_ref_cycles) && $stable(res_events) && $stable(res_timeout)));

   // R3
   gate_min_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (res_valid && !res_timeout) |-> (res_ref_cycles >= GATE_REF && res_ref_cycles <= TMO_REF));

   // R6
   tmo_shape_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (res_valid && res_timeout) |-> (res_events == '0 && res_ref_cycles == TMO_REF));

   // R7
   evt_nonzero_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (res_valid && !res_timeout) |-> (res_events != '0));
endmodule

bind recip_freq_counter rfc_checker #(
   .GATE_CYCLES(GATE_CYCLES),
   .TMO_MULT   (TMO_MULT),
   .EVT_W      (EVT_W),
   .REF_W      (REF_W)
) u_rfc_checker (
   .clk_ref       (clk_ref),
   .rst_n         (rst_n),
   .res_valid     (res_valid),
   .res_timeout   (res_timeout),
   .res_events    (res_events),
   .res_ref_cycles(res_ref_cycles)
);

// File: tb/recip_freq_counter_bench.sv
`timescale 1ns/1ps
module recip_freq_counter_bench;
   localparam int GATE  = 200;
   localparam int TMULT = 4;
   localparam int EW    = 5;
   localparam int RW    = 32;
   localparam int NS    = 2;
   localparam int EMAX  = (1 << EW) - 1;

   logic          clk_ref = 1'b0;
   logic          rst_n   = 1'b0;
   logic          sig_in  = 1'b0;
   logic          res_valid, res_timeout;
   logic [EW-1:0] res_events;
   logic [RW-1:0] res_ref_cycles;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   recip_freq_counter #(
      .GATE_CYCLES(GATE), .TMO_MULT(TMULT), .EVT_W(EW), .REF_W(RW), .SYNC_STAGES(NS)
   ) u_recip_freq_counter (
      .clk_ref(clk_ref), .rst_n(rst_n), .sig_in(sig_in),
      .res_valid(res_valid), .res_timeout(res_timeout),
      .res_events(res_events), .res_ref_cycles(res_ref_cycles)
   );

   always #2.5 clk_ref = ~clk_ref;

   // Behavioural reference: sample history, gate distance, edge tally.
   bit hist[$];
   bit m_open;
   int m_dist, m_edges;
   bit x_valid, x_tmo;
   int x_evt, x_ref;

   always @(posedge clk_ref) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i < NS + 2; i++) hist.push_back(1'b0);
         m_open = 0; m_dist = 0; m_edges = 0;
         x_valid = 0; x_tmo = 0; x_evt = 0; x_ref = 0;
      end else begin
         bit edge_seen;
         hist.push_front(sig_in);
         void'(hist.pop_back());
         edge_seen = hist[NS] && !hist[NS+1];
         x_valid = 0;
         if (!m_open) begin
            if (edge_seen) begin m_open = 1; m_dist = 1; m_edges = 0; end
         end else if (edge_seen && m_dist >= GATE) begin
            x_valid = 1; x_tmo = 0; x_ref = m_dist;
            x_evt = (m_edges + 1 > EMAX) ? EMAX : m_edges + 1;
            m_dist = 1; m_edges = 0;
         end else if (!edge_seen && m_dist == GATE * TMULT) begin
            x_valid = 1; x_tmo = 1; x_ref = m_dist; x_evt = 0;
            m_open = 0; m_dist = 0; m_edges = 0;
         end else begin
            m_dist = m_dist + 1;
            if (edge_seen) m_edges = m_edges + 1;
         end
      end
   end

   // Result log taken at the ports.
   int log_evt[$], log_ref[$], log_tmo[$], log_cyc[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(negedge clk_ref) begin
      if (rst_n) begin
         check(res_valid == x_valid, "R1 R8 valid vs model", int'(res_valid), int'(x_valid));
         check(int'(res_ref_cycles) == x_ref, "R3 ref vs model", int'(res_ref_cycles), x_ref);
         check(int'(res_events) == x_evt, "R4 events vs model", int'(res_events), x_evt);
         check(res_timeout == x_tmo, "R6 timeout vs model", int'(res_timeout), int'(x_tmo));
         if (res_valid) begin
            log_evt.push_back(int'(res_events));
            log_ref.push_back(int'(res_ref_cycles));
            log_tmo.push_back(int'(res_timeout));
            log_cyc.push_back(cyc);
         end
      end
   end

   task automatic clear_log();
      log_evt.delete(); log_ref.delete(); log_tmo.delete(); log_cyc.delete();
   endtask

   task automatic wave(input int period, input int ncyc);
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk_ref);
         sig_in <= ((c % period) < (period / 2));
      end
   endtask

   task automatic hold_low(input int ncyc);
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk_ref);
         sig_in <= 1'b0;
      end
   endtask

   task automatic steady(input int period, input string req);
      int n, want_ref, want_evt, last;
      n        = (GATE + period - 1) / period;
      want_ref = n * period;
      want_evt = (n > EMAX) ? EMAX : n;
      clear_log();
      wave(period, 1200);
      last = log_ref.size() - 1;
      check(log_ref.size() >= 3, req, log_ref.size(), 3);
      if (last >= 1) begin
         check(log_ref[last] == want_ref, "R3 steady ref", log_ref[last], want_ref);
         check(log_evt[last] == want_evt, req, log_evt[last], want_evt);
         check(log_tmo[last] == 0, "R6 no timeout on live input", log_tmo[last], 0);
         // R5: gates share boundary edges
         check(log_cyc[last] - log_cyc[last-1] == log_ref[last], "R5 gap-free spacing",
               log_cyc[last] - log_cyc[last-1], log_ref[last]);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk_ref);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      repeat (4) @(negedge clk_ref);
      rst_n <= 1'b1;
      @(negedge clk_ref);
      // R2: reset state
      check(res_valid == 0 && res_timeout == 0, "R2 reset flags", int'(res_valid), 0);
      check(res_events == 0 && res_ref_cycles == 0, "R2 reset data", int'(res_ref_cycles), 0);

      // R2: first gate after reset opens silently
      clear_log();
      wave(10, 150);
      check(log_ref.size() == 0, "R2 no result from opening edge", log_ref.size(), 0);

      steady(10, "R4 events exact division");
      steady(7, "R4 events with overrun");
      steady(4, "R7 event saturation");
      steady(10, "R4 events after saturation");

      // R6: input stops, timeout result
      clear_log();
      hold_low(1000);
      check(log_tmo.size() >= 1, "R6 timeout emitted", log_tmo.size(), 1);
      if (log_tmo.size() >= 1) begin
         check(log_tmo[log_tmo.size()-1] == 1, "R6 timeout flag", log_tmo[log_tmo.size()-1], 1);
         check(log_evt[log_evt.size()-1] == 0, "R6 timeout events", log_evt[log_evt.size()-1], 0);
         check(log_ref[log_ref.size()-1] == GATE * TMULT, "R6 timeout span",
               log_ref[log_ref.size()-1], GATE * TMULT);
      end

      // R2 R6: idle after timeout, reopening edge gives no result
      clear_log();
      wave(10, 150);
      check(log_ref.size() == 0, "R6 idle reopen silent", log_ref.size(), 0);
      steady(10, "R4 events after timeout");

      repeat (4) @(negedge clk_ref);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule